// File: doc/BRIEF.md
# Device-to-PIRQ Route Register File

This block holds the interrupt-route registers that assign each PCI device's four INTx pins to one of eight shared interrupt lines, PIRQ A to H (index 0 to 7). There is one 16-bit route register for each device number from 25 to 31. A small byte-addressed access port reads and writes them inside a 16 KiB window. The stored values are decoded at once into a pin-to-PIRQ table.

A combinational lookup port takes a 5-bit device number and a 2-bit INTx pin and returns the 3-bit PIRQ index. Device 30 ignores its register and always routes INTA..INTD to PIRQ E..H. Devices outside 25..31 follow a fixed rotating formula that only uses PIRQ E..H.

Accesses are little endian and 1, 2 or 4 bytes long. The address is reduced to the window. An access that would run past the window end is cut short and does not wrap.

Top module: `prt_route_file`

## Requirements
- R1: Reset state. After an asynchronous reset, the register for device s (s = 25..31) sits at window offset 4*(s-25) and reads ROUTE_DEFAULT (default 16'h3210). The exception is device 30, whose register reads zero. Every other byte of the window reads zero.
- R2: For devices 25..29 and 31, the route register holds four 4-bit fields. The field for pin n (INTA=0 .. INTD=3) occupies bits [4n+3:4n]. The lookup returns the low 3 bits of that field; bit 4n+3 has no effect.
- R3: Device 30 always looks up as PIRQ index 4 + pin. Writes to its register have no effect, and the register reads back zero.
- R4: For a device number outside 25..31, the lookup returns ((device + pin) mod 4) + 4.
- R5: Writes are little endian. Byte k of wr_data_i goes to window address base+k, for k below the access length. A single access may span two registers.
- R6: A read of length L returns the addressed bytes in the low L bytes of rd_data_o. The upper bytes are zero.
- R7: Only the low 14 bits of acc_addr_i select a byte. Upper address bits are ignored.
- R8: If base + length exceeds 16384, only the bytes up to the window end are read or written. Nothing wraps to offset 0.
- R9: Bytes outside the route registers, including the upper two bytes of each 4-byte register slot, read zero. Writes to them have no effect.
- R10: A write takes effect at the clock edge where wr_en_i is high. Lookups and reads reflect it from that edge on, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_addr_i | input | 32 | Access byte address (reduced to window) |
| acc_len_i | input | 3 | Access length in bytes (1, 2 or 4) |
| wr_en_i | input | 1 | Write strobe, sampled at rising clock edge |
| wr_data_i | input | 32 | Write data, little endian |
| rd_data_o | output | 32 | Combinational read data, zero-extended |
| lk_slot_i | input | 5 | Lookup device number |
| lk_pin_i | input | 2 | Lookup INTx pin (0 = INTA) |
| lk_pirq_o | output | 3 | PIRQ index for the looked-up pin |

## Verification
Reads and lookups are combinational, so their results are due in the same cycle as the inputs. The bench drives inputs on the falling edge and samples a quarter period later, well before the next rising edge. A write is due one rising edge after the strobe. The bench therefore checks its effect only from the following falling edge on. It also checks a lookup in the cycle of the write strobe to confirm that the old value is still seen there. Reset is asynchronous, so its effect is checked shortly after rst_ni falls, with no clock edge in between.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned SLOT_W         = 5;
  localparam int unsigned PIN_W          = 2;
  localparam int unsigned NUM_PINS       = 4;
  localparam int unsigned PIRQ_W         = 3;
  localparam int unsigned FIELD_W        = 4;
  localparam int unsigned FIRST_SLOT     = 25;
  localparam int unsigned NUM_ROUTE_REGS = 7;
  localparam int unsigned FIXED_SLOT     = 30;
  localparam int unsigned FIXED_IDX      = FIXED_SLOT - FIRST_SLOT;
  localparam int unsigned REG_BYTES      = 2;
  localparam int unsigned REG_W          = 8 * REG_BYTES;

  typedef logic [PIRQ_W-1:0] pirq_t;
  typedef logic [NUM_PINS-1:0][PIRQ_W-1:0] pin_map_t;

  // upper half of the PIRQ set, rotated by slot and pin
  function automatic pirq_t default_pirq(logic [SLOT_W-1:0] slot, logic [PIN_W-1:0] pin);
    logic [1:0] rot;
    rot = slot[1:0] + pin;
    return {1'b1, rot};
  endfunction

  function automatic pirq_t fixed_pirq(logic [PIN_W-1:0] pin);
    return {1'b1, pin};
  endfunction
endpackage

// File: rtl/prt_access_lanes.sv
module prt_access_lanes #(
  parameter int unsigned WIN_AW = 14,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [WIN_AW-1:0]             base_i,
  input  logic [LEN_W-1:0]              len_i,
  output logic [LANES-1:0]              lane_en_o,
  output logic [LANES-1:0][WIN_AW-1:0]  lane_addr_o
);
  localparam int unsigned RoomW = WIN_AW + 1;
  localparam logic [RoomW-1:0] WinSize = RoomW'(1) << WIN_AW;

  logic [RoomW-1:0] room;
  logic [RoomW-1:0] len_ext;
  logic [RoomW-1:0] eff_len;

  assign room    = WinSize - {1'b0, base_i};
  assign len_ext = RoomW'(len_i);
  // clip at window end instead of wrapping
  assign eff_len = (len_ext > room) ? room : len_ext;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_en_o[k]   = RoomW'(k) < eff_len;
    assign lane_addr_o[k] = base_i + WIN_AW'(k);
  end
endmodule

// File: rtl/prt_route_regs.sv
module prt_route_regs #(
  parameter int unsigned WIN_AW     = 14,
  parameter int unsigned LANES      = 4,
  parameter int unsigned NUM_REGS   = 7,
  parameter int unsigned REG_BYTES  = 2,
  parameter int unsigned REG_STRIDE = 4,
  parameter int unsigned FIXED_IDX  = 5,
  parameter logic [WIN_AW-1:0]      REG_BASE      = '0,
  parameter logic [8*REG_BYTES-1:0] ROUTE_DEFAULT = '0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [LANES-1:0]                     lane_en_i,
  input  logic [LANES-1:0][WIN_AW-1:0]         lane_addr_i,
  input  logic [8*LANES-1:0]                   wr_data_i,
  output logic [NUM_REGS-1:0][8*REG_BYTES-1:0] regs_o,
  output logic [8*LANES-1:0]                   rd_data_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
      localparam logic [WIN_AW-1:0] ByteAddr = WIN_AW'(REG_BASE + REG_STRIDE * r + b);
      if (r == FIXED_IDX) begin : g_fixed
        assign regs_o[r][8*b +: 8] = 8'h00;
      end else begin : g_store
        logic [7:0] byte_q;
        logic [7:0] byte_d;

        always_comb begin
          byte_d = byte_q;
          for (int k = 0; k < LANES; k++) begin
            if (wr_en_i && lane_en_i[k] && (lane_addr_i[k] == ByteAddr)) begin
              byte_d = wr_data_i[8*k +: 8];
            end
          end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) byte_q <= ROUTE_DEFAULT[8*b +: 8];
          else         byte_q <= byte_d;
        end

        assign regs_o[r][8*b +: 8] = byte_q;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_en_i[k]) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          for (int b = 0; b < REG_BYTES; b++) begin
            if (lane_addr_i[k] == WIN_AW'(REG_BASE + REG_STRIDE * r + b)) begin
              rd_data_o[8*k +: 8] = regs_o[r][8*b +: 8];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/prt_route_decode.sv
module prt_route_decode
  import prt_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 7,
  parameter int unsigned RW        = 16,
  parameter int unsigned BASE_SLOT = 25,
  parameter int unsigned FIX_IDX   = 5
) (
  input  logic [NUM_REGS-1:0][RW-1:0] regs_i,
  input  logic [SLOT_W-1:0]           lk_slot_i,
  input  logic [PIN_W-1:0]            lk_pin_i,
  output pirq_t                       lk_pirq_o
);
  pin_map_t    route_tbl [NUM_REGS];
  int unsigned slot_n;
  int unsigned row;
  logic        in_range;
  logic        unused_bits;

  // rebuilt combinationally from the stored registers
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (r == FIX_IDX) route_tbl[r][p] = fixed_pirq(PIN_W'(p));
        else              route_tbl[r][p] = regs_i[r][FIELD_W*p +: PIRQ_W];
      end
    end
  end

  always_comb begin
    slot_n   = 32'(lk_slot_i);
    in_range = (slot_n >= BASE_SLOT) && (slot_n < BASE_SLOT + NUM_REGS);
    row      = in_range ? (slot_n - BASE_SLOT) : 0;
    if (in_range) lk_pirq_o = route_tbl[row][lk_pin_i];
    else          lk_pirq_o = default_pirq(lk_slot_i, lk_pin_i);
  end

  assign unused_bits = ^regs_i;
endmodule

// File: rtl/prt_route_file.sv
module prt_route_file
  import prt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WIN_AW     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned REG_STRIDE = 4,
  parameter logic [WIN_AW-1:0] REG_BASE      = '0,
  parameter logic [REG_W-1:0]  ROUTE_DEFAULT = 16'h3210
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [SLOT_W-1:0] lk_slot_i,
  input  logic [PIN_W-1:0]  lk_pin_i,
  output logic [PIRQ_W-1:0] lk_pirq_o
);
  localparam int unsigned Lanes = DATA_W / 8;

  logic [Lanes-1:0]                    lane_en;
  logic [Lanes-1:0][WIN_AW-1:0]        lane_addr;
  logic [NUM_ROUTE_REGS-1:0][REG_W-1:0] regs;
  logic                                unused_addr_hi;

  assign unused_addr_hi = ^acc_addr_i[ADDR_W-1:WIN_AW];

  prt_access_lanes #(
    .WIN_AW (WIN_AW),
    .LANES  (Lanes),
    .LEN_W  (LEN_W)
  ) u_lanes (
    .base_i      (acc_addr_i[WIN_AW-1:0]),
    .len_i       (acc_len_i),
    .lane_en_o   (lane_en),
    .lane_addr_o (lane_addr)
  );

  prt_route_regs #(
    .WIN_AW        (WIN_AW),
    .LANES         (Lanes),
    .NUM_REGS      (NUM_ROUTE_REGS),
    .REG_BYTES     (REG_BYTES),
    .REG_STRIDE    (REG_STRIDE),
    .FIXED_IDX     (FIXED_IDX),
    .REG_BASE      (REG_BASE),
    .ROUTE_DEFAULT (ROUTE_DEFAULT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .lane_en_i   (lane_en),
    .lane_addr_i (lane_addr),
    .wr_data_i   (wr_data_i),
    .regs_o      (regs),
    .rd_data_o   (rd_data_o)
  );

  prt_route_decode #(
    .NUM_REGS  (NUM_ROUTE_REGS),
    .RW        (REG_W),
    .BASE_SLOT (FIRST_SLOT),
    .FIX_IDX   (FIXED_IDX)
  ) u_decode (
    .regs_i    (regs),
    .lk_slot_i (lk_slot_i),
    .lk_pin_i  (lk_pin_i),
    .lk_pirq_o (lk_pirq_o)
  );
endmodule

// File: rtl/prt_route_file_chk.sv
module prt_route_file_chk
  import prt_pkg::*;
#(
  parameter int unsigned WIN_AW     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned REG_STRIDE = 4,
  parameter logic [WIN_AW-1:0] REG_BASE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WIN_AW-1:0] acc_win_i,
  input logic [LEN_W-1:0]  acc_len_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [SLOT_W-1:0] lk_slot_i,
  input logic [PIN_W-1:0]  lk_pin_i,
  input logic [PIRQ_W-1:0] lk_pirq_o
);
  localparam logic [WIN_AW-1:0] FixedAddr = WIN_AW'(REG_BASE + REG_STRIDE * FIXED_IDX);

  p_fixed_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lk_slot_i) == FIXED_SLOT) |-> (lk_pirq_o == {1'b1, lk_pin_i}));

  p_fixed_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_win_i == FixedAddr && acc_len_i == LEN_W'(2)) |-> (rd_data_o == '0));

  p_default_low_slots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lk_slot_i) < FIRST_SLOT) |->
      (lk_pirq_o[2] && (lk_pirq_o[1:0] == 2'(lk_slot_i[1:0] + lk_pin_i))));

  p_zero_ext_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_len_i == LEN_W'(1)) |-> (rd_data_o[DATA_W-1:8] == '0));

  p_zero_ext_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_len_i == LEN_W'(2)) |-> (rd_data_o[DATA_W-1:16] == '0));

  p_read_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!($stable(acc_win_i) && $stable(acc_len_i)) || $stable(rd_data_o)));

  p_lookup_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!($stable(lk_slot_i) && $stable(lk_pin_i)) || $stable(lk_pirq_o)));
endmodule

bind prt_route_file prt_route_file_chk #(
  .WIN_AW     (WIN_AW),
  .DATA_W     (DATA_W),
  .LEN_W      (LEN_W),
  .REG_STRIDE (REG_STRIDE),
  .REG_BASE   (REG_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_win_i (acc_addr_i[WIN_AW-1:0]),
  .acc_len_i (acc_len_i),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .lk_slot_i (lk_slot_i),
  .lk_pin_i  (lk_pin_i),
  .lk_pirq_o (lk_pirq_o)
);

// File: tb/tb_prt_route_file.sv
module tb_prt_route_file;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_LK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;  // slot in [4:0] for lookups
    logic [2:0]  len;   // pin in [1:0] for lookups
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 32'h0000_0000, 3'd2, 32'h0, 32'h0000_3210, 4'd1},  // R1 dev25
    '{OP_RD, 32'h0000_0014, 3'd4, 32'h0, 32'h0000_0000, 4'd1},  // R1 dev30 zero
    '{OP_RD, 32'h0000_0018, 3'd4, 32'h0, 32'h0000_3210, 4'd1},  // R1 dev31
    '{OP_RD, 32'h0000_0002, 3'd2, 32'h0, 32'h0000_0000, 4'd9},  // R9 gap bytes
    '{OP_LK, 32'd25,        3'd0, 32'h0, 32'd0,         4'd2},  // R2
    '{OP_LK, 32'd25,        3'd3, 32'h0, 32'd3,         4'd2},
    '{OP_LK, 32'd30,        3'd0, 32'h0, 32'd4,         4'd3},  // R3
    '{OP_LK, 32'd30,        3'd3, 32'h0, 32'd7,         4'd3},
    '{OP_LK, 32'd0,         3'd0, 32'h0, 32'd4,         4'd4},  // R4
    '{OP_LK, 32'd5,         3'd2, 32'h0, 32'd7,         4'd4},
    '{OP_LK, 32'd24,        3'd3, 32'h0, 32'd7,         4'd4},
    '{OP_LK, 32'd3,         3'd1, 32'h0, 32'd4,         4'd4},
    '{OP_WR, 32'h0000_0004, 3'd4, 32'hAABB_7654, 32'h0, 4'd5},
    '{OP_RD, 32'h0000_0004, 3'd4, 32'h0, 32'h0000_7654, 4'd9},  // R9 upper dropped
    '{OP_LK, 32'd26,        3'd0, 32'h0, 32'd4,         4'd10}, // R10
    '{OP_LK, 32'd26,        3'd3, 32'h0, 32'd7,         4'd10},
    '{OP_WR, 32'h0000_0009, 3'd1, 32'h0000_000F, 32'h0, 4'd5},
    '{OP_RD, 32'h0000_0008, 3'd1, 32'h0, 32'h0000_0010, 4'd6},  // R6
    '{OP_RD, 32'h0000_0008, 3'd2, 32'h0, 32'h0000_0F10, 4'd5},  // R5
    '{OP_LK, 32'd27,        3'd2, 32'h0, 32'd7,         4'd2},  // R2 bit3 ignored
    '{OP_LK, 32'd27,        3'd3, 32'h0, 32'd0,         4'd2},
    '{OP_WR, 32'h0000_0014, 3'd2, 32'h0000_1111, 32'h0, 4'd3},
    '{OP_RD, 32'h0000_0014, 3'd4, 32'h0, 32'h0000_0000, 4'd3},  // R3 write ignored
    '{OP_LK, 32'd30,        3'd1, 32'h0, 32'd5,         4'd3},
    '{OP_WR, 32'hFFFF_C00C, 3'd2, 32'h0000_5555, 32'h0, 4'd7},
    '{OP_RD, 32'h0000_000C, 3'd2, 32'h0, 32'h0000_5555, 4'd7},  // R7
    '{OP_LK, 32'd28,        3'd0, 32'h0, 32'd5,         4'd7},
    '{OP_WR, 32'h0000_3FFE, 3'd4, 32'h9999_9999, 32'h0, 4'd8},
    '{OP_RD, 32'h0000_0000, 3'd2, 32'h0, 32'h0000_3210, 4'd8},  // R8 no wrap
    '{OP_RD, 32'h0000_3FFE, 3'd4, 32'h0, 32'h0000_0000, 4'd8},
    '{OP_WR, 32'h0000_0002, 3'd4, 32'h1234_5678, 32'h0, 4'd5},
    '{OP_RD, 32'h0000_0004, 3'd2, 32'h0, 32'h0000_1234, 4'd5},  // R5 span
    '{OP_RD, 32'h0000_0002, 3'd4, 32'h0, 32'h1234_0000, 4'd5},
    '{OP_RD, 32'h0000_0000, 3'd2, 32'h0, 32'h0000_3210, 4'd9},
    '{OP_RD, 32'h0001_0018, 3'd2, 32'h0, 32'h0000_3210, 4'd7},  // R7 alias
    '{OP_LK, 32'd31,        3'd1, 32'h0, 32'd1,         4'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] acc_addr;
  logic [2:0]  acc_len;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [4:0]  lk_slot;
  logic [1:0]  lk_pin;
  logic [2:0]  lk_pirq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  prt_route_file dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .acc_addr_i (acc_addr),
    .acc_len_i  (acc_len),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .lk_slot_i  (lk_slot),
    .lk_pin_i   (lk_pin),
    .lk_pirq_o  (lk_pirq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; acc_addr = '0; acc_len = 3'd4;
    wr_data = '0; lk_slot = '0; lk_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (VECS[i].op == OP_WR) begin
        acc_addr = VECS[i].addr; acc_len = VECS[i].len;
        wr_data  = VECS[i].data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
      end else if (VECS[i].op == OP_RD) begin
        acc_addr = VECS[i].addr; acc_len = VECS[i].len;
        #(CLK_PERIOD/4);
        check(rd_data, VECS[i].exp, int'(VECS[i].req));
      end else begin
        lk_slot = VECS[i].addr[4:0]; lk_pin = VECS[i].len[1:0];
        #(CLK_PERIOD/4);
        check({29'd0, lk_pirq}, VECS[i].exp, int'(VECS[i].req));
      end
    end

    // R10: lookup keeps old value until the write edge
    @(negedge clk);
    acc_addr = 32'h18; acc_len = 3'd2; wr_data = 32'h0000_0777; wr_en = 1'b1;
    lk_slot = 5'd31; lk_pin = 2'd0;
    #(CLK_PERIOD/4);
    check({29'd0, lk_pirq}, 32'd0, 10);
    @(negedge clk);
    wr_en = 1'b0;
    #(CLK_PERIOD/4);
    check({29'd0, lk_pirq}, 32'd7, 10);

    // R1: asynchronous reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    acc_addr = 32'h4; acc_len = 3'd4;
    lk_slot = 5'd28; lk_pin = 2'd0;
    #(CLK_PERIOD/4);
    check(rd_data, 32'h0000_3210, 1);
    check({29'd0, lk_pirq}, 32'd0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    acc_addr = 32'h18;
    #(CLK_PERIOD/4);
    check(rd_data, 32'h0000_3210, 1);

    done = 1'b1;
    finish_run();
  end
endmodule